// File: doc/BRIEF.md
# Boot-Overlay Memory Map Decoder

This block sits on a 16-bit big-endian processor bus and steers each bus cycle to one of three places: a read-only word array, a read/write word array, or the peripheral space. The top address range is peripheral space. Any cycle that lands there raises a peripheral-cycle flag and leaves both memories alone. Below that range, one word-address bit picks read-only memory over read/write memory. Each array is indexed by the word address modulo its depth, so both repeat through their windows.

From reset, a boot overlay flag maps read-only memory over all non-peripheral addresses. This lets the processor fetch its start-up code from address zero. A pulse on the overlay-clear input drops the flag, and the flag stays down until the next reset. The block serves word and byte reads, and word and byte writes. A byte write merges into the addressed lane only, and byte lanes are ordered big-endian.

A second small function counts bus half-cycles into a peripheral clock. It emits one tick for every ten half-cycles and carries the remainder from one clock to the next.

Top module: `bootmap_decoder`

## Requirements
- R1: A valid cycle whose byte address is at or above 0x800000 drives `periph_cycle` high in the same cycle. It produces no `rd_valid` and changes no memory word, even when its low address bits alias a RAM word.
- R2: Below 0x800000, ROM is selected when byte-address bit 22 is set or the overlay flag is set. Otherwise RAM is selected.
- R3: ROM is indexed by word address modulo ROM depth (1024 words by default), and RAM by word address modulo RAM depth (2048 words by default). Addresses one depth apart return the same word.
- R4: A write cycle that decodes to ROM leaves ROM contents unchanged. Word index i of ROM holds {i[7:0]^8'hC3, i[15:8]^(i[7:0]+8'h17)}.
- R5: A word read (`bus_byte`=0) returns the full 16-bit word on `rd_data`, with `rd_valid` high, one clock after the cycle is presented.
- R6: A byte read (`bus_byte`=1) returns the addressed lane on `rd_data[7:0]` with `rd_data[15:8]`=0. Even byte address (`bus_addr[0]`=0) selects bits 15:8, and odd selects bits 7:0.
- R7: A byte write to RAM replaces only the addressed lane with `bus_wdata[7:0]` and keeps the other lane. A word write replaces all 16 bits.
- R8: The overlay flag (`overlay_on`) is 1 after reset. It falls one clock after `overlay_clr` is sampled high, and stays 0 until the next reset.
- R9: A cycle with `bus_valid`=0 or `bus_ds`=0 performs no memory read or write.
- R10: Each clock adds `hc_len` to a remainder below 10. One clock later, `pclk_ticks` shows the number of whole tens in that sum, and the remainder is kept for the next clock.
- R11: After reset, `rd_valid`=0 and `pclk_ticks`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus operation is present this cycle |
| bus_ds | input | 1 | Data strobe active |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_addr | input | 24 | Byte address; bit 0 picks the lane |
| bus_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| hc_len | input | 4 | Half-cycles elapsed this clock |
| overlay_clr | input | 1 | Clears the boot overlay flag |
| periph_cycle | output | 1 | Current cycle addresses peripheral space |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| overlay_on | output | 1 | Boot overlay flag |
| pclk_ticks | output | 2 | Peripheral clock ticks produced last clock |

## Verification
`periph_cycle` is combinational, so the bench checks it shortly after driving a cycle, before the next edge. Read data, `overlay_on` and `pclk_ticks` all appear one clock after the edge that samples their stimulus. Each expected read is queued with the cycle number in which it is due. A monitor compares it on the falling edge of that cycle and flags any read data that arrives early, late or without a matching request. Tick counts are compared just after the following rising edge, against a remainder model that the bench carries on its own.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    RGN_RAM = 2'd0,
    RGN_ROM = 2'd1,
    RGN_IO  = 2'd2
  } region_e;

  // Big-endian lane order: lane 0 (even byte) sits in bits 15:8.
  function automatic logic [3:0] lane_shift(input logic lane);
    return lane ? 4'd0 : 4'd8;
  endfunction

  function automatic logic [15:0] lane_mask(input logic lane);
    return 16'h00FF << lane_shift(lane);
  endfunction

  function automatic logic [7:0] lane_pick(input logic [15:0] word, input logic lane);
    return 8'(word >> lane_shift(lane));
  endfunction

  function automatic logic [15:0] lane_merge(input logic [15:0] old_word,
                                             input logic [7:0]  new_byte,
                                             input logic        lane);
    return (old_word & ~lane_mask(lane)) | (16'(new_byte) << lane_shift(lane));
  endfunction

  // Read-only image: a content pattern computed from the word index.
  function automatic logic [15:0] rom_image(input logic [15:0] idx);
    logic [7:0] lo_part;
    lo_part = idx[7:0] + 8'h17;
    return {idx[7:0] ^ 8'hC3, idx[15:8] ^ lo_part};
  endfunction

endpackage

// File: rtl/region_decode.sv
module region_decode
  import memmap_pkg::*;
#(
  parameter int WADDR_W     = 23,
  parameter int IO_WBASE    = 32'h40_0000,
  parameter int ROM_SEL_BIT = 21
) (
  input  logic [WADDR_W-1:0] waddr,
  input  logic               overlay,
  output region_e            region
);

  localparam logic [WADDR_W-1:0] IoBase = WADDR_W'(IO_WBASE);

  always_comb begin
    if (waddr >= IoBase)                     region = RGN_IO;
    else if (waddr[ROM_SEL_BIT] || overlay)  region = RGN_ROM;
    else                                     region = RGN_RAM;
  end

endmodule

// File: rtl/word_ram.sv
module word_ram #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int Depth = 1 << AW;

  logic [DW-1:0] mem [Depth];

  assign rdata = mem[idx];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

endmodule

// File: rtl/pattern_rom.sv
module pattern_rom
  import memmap_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0] idx,
  output logic [15:0]   rdata
);

  assign rdata = rom_image(16'(idx));

endmodule

// File: rtl/halfcycle_divider.sv
module halfcycle_divider #(
  parameter int DIV    = 10,
  parameter int LEN_W  = 4,
  parameter int TICK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  hc_len,
  output logic [TICK_W-1:0] ticks
);

  localparam int ACC_W = $clog2(DIV);
  localparam int SUM_W = ((ACC_W > LEN_W) ? ACC_W : LEN_W) + 1;
  localparam logic [SUM_W-1:0] DivS = SUM_W'(DIV);

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic [ACC_W-1:0] acc_next;
  logic [TICK_W-1:0] ticks_next;

  always_comb begin
    sum        = SUM_W'(acc_q) + SUM_W'(hc_len);
    acc_next   = ACC_W'(sum % DivS);
    ticks_next = TICK_W'(sum / DivS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ticks <= '0;
    end else begin
      acc_q <= acc_next;
      ticks <= ticks_next;
    end
  end

  // R10
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_q) < DIV);

endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
  import memmap_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int IO_WBASE    = 32'h40_0000,
  parameter int ROM_SEL_BIT = 21,
  parameter int ROM_AW      = 10,
  parameter int RAM_AW      = 11,
  parameter int DIV         = 10,
  parameter int LEN_W       = 4,
  parameter int TICK_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_ds,
  input  logic              bus_rd,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic [LEN_W-1:0]  hc_len,
  input  logic              overlay_clr,
  output logic              periph_cycle,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              overlay_on,
  output logic [TICK_W-1:0] pclk_ticks
);

  localparam int WADDR_W = ADDR_W - 1;

  logic [WADDR_W-1:0] waddr;
  logic               lane;
  logic               overlay_q;
  region_e            region;

  logic               access;
  logic               mem_hit;
  logic               rd_hit;
  logic               ram_we;
  logic               rom_write_drop;

  logic [15:0]        ram_word;
  logic [15:0]        rom_word;
  logic [15:0]        sel_word;
  logic [15:0]        ram_wword;

  assign waddr = bus_addr[ADDR_W-1:1];
  assign lane  = bus_addr[0];

  region_decode #(
    .WADDR_W    (WADDR_W),
    .IO_WBASE   (IO_WBASE),
    .ROM_SEL_BIT(ROM_SEL_BIT)
  ) u_decode (
    .waddr  (waddr),
    .overlay(overlay_q),
    .region (region)
  );

  // Named access events
  assign access         = bus_valid && bus_ds;
  assign periph_cycle   = bus_valid && (region == RGN_IO);
  assign mem_hit        = access && (region != RGN_IO);
  assign rd_hit         = mem_hit && bus_rd;
  assign ram_we         = mem_hit && !bus_rd && (region == RGN_RAM);
  assign rom_write_drop = mem_hit && !bus_rd && (region == RGN_ROM);

  assign ram_wword = bus_byte ? lane_merge(ram_word, bus_wdata[7:0], lane) : bus_wdata;

  word_ram #(.AW(RAM_AW), .DW(16)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .idx  (waddr[RAM_AW-1:0]),
    .wdata(ram_wword),
    .rdata(ram_word)
  );

  pattern_rom #(.AW(ROM_AW)) u_rom (
    .idx  (waddr[ROM_AW-1:0]),
    .rdata(rom_word)
  );

  assign sel_word = (region == RGN_ROM) ? rom_word : ram_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_hit;
      if (rd_hit) rd_data <= bus_byte ? {8'h00, lane_pick(sel_word, lane)} : sel_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           overlay_q <= 1'b1;
    else if (overlay_clr) overlay_q <= 1'b0;
  end

  assign overlay_on = overlay_q;

  halfcycle_divider #(.DIV(DIV), .LEN_W(LEN_W), .TICK_W(TICK_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .hc_len(hc_len),
    .ticks (pclk_ticks)
  );

  // R1
  io_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_cycle |-> (!ram_we && !rd_hit));

  // R4
  rom_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_write_drop |-> !ram_we);

  // R8
  overlay_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_q |=> !overlay_q);

  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rd_valid);

  // R9
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> !rd_valid);

endmodule

// File: tb/bootmap_decoder_tb.sv
module bootmap_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROM_WORDS  = 1024;
  localparam int RAM_WORDS  = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_ds = 1'b0, bus_rd = 1'b0, bus_byte = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [3:0]  hc_len = '0;
  logic        overlay_clr = 1'b0;
  logic        periph_cycle, rd_valid, overlay_on;
  logic [15:0] rd_data;
  logic [1:0]  pclk_ticks;

  bootmap_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ds(bus_ds),
    .bus_rd(bus_rd), .bus_byte(bus_byte), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .hc_len(hc_len), .overlay_clr(overlay_clr),
    .periph_cycle(periph_cycle), .rd_valid(rd_valid), .rd_data(rd_data),
    .overlay_on(overlay_on), .pclk_ticks(pclk_ticks)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [15:0] data;
    int          due;
    string       req;
  } exp_t;

  exp_t        exp_q[$];
  logic [15:0] ram_ref [RAM_WORDS];
  bit          ovl_ref = 1'b1;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] exp_rom(input int idx);
    int low8, high8;
    low8  = idx % 256;
    high8 = (idx / 256) % 256;
    return {8'(low8 ^ 'hC3), 8'(high8 ^ ((low8 + 'h17) % 256))};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (exp_q.size() == 0 || exp_q[0].due != cyc) begin
          n_chk++; n_fail++;
          $display("FAIL R9 unrequested read data: actual %h expected none", rd_data);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          check(it.req, 32'(rd_data), 32'(it.data), "read data");
        end
      end else if (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        exp_t it;
        it = exp_q.pop_front();
        n_chk++; n_fail++;
        $display("FAIL %s missing read: actual none expected %h", it.req, it.data);
      end
    end
  end

  // Driver: presents one cycle, updates the reference model
  task automatic bus_op(input bit vld, input bit ds, input bit rd, input bit byt,
                        input logic [23:0] a, input logic [15:0] wd, input string req);
    bit is_io, is_rom, ln;
    int word;
    logic [15:0] w;
    exp_t it;
    @(posedge clk);
    #1;
    bus_valid = vld; bus_ds = ds; bus_rd = rd; bus_byte = byt;
    bus_addr = a; bus_wdata = wd; overlay_clr = 1'b0;
    word   = int'(a) / 2;
    ln     = a[0];
    is_io  = (a >= 24'h80_0000);
    is_rom = !is_io && (a[22] || ovl_ref);
    #1;
    check(is_io ? "R1" : req, 32'(periph_cycle), 32'(vld && is_io), "periph_cycle");
    if (vld && ds && !is_io) begin
      if (rd) begin
        w = is_rom ? exp_rom(word % ROM_WORDS) : ram_ref[word % RAM_WORDS];
        it.data = byt ? {8'h00, (ln ? w[7:0] : w[15:8])} : w;
        it.due  = cyc + 1;
        it.req  = req;
        exp_q.push_back(it);
      end else if (!is_rom) begin
        if (!byt)    ram_ref[word % RAM_WORDS] = wd;
        else if (ln) ram_ref[word % RAM_WORDS][7:0]  = wd[7:0];
        else         ram_ref[word % RAM_WORDS][15:8] = wd[7:0];
      end
    end
  endtask

  task automatic bus_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      bus_valid = 1'b0; bus_ds = 1'b0; overlay_clr = 1'b0;
    end
  endtask

  task automatic drop_overlay();
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_ds = 1'b0; overlay_clr = 1'b1;
    @(posedge clk);
    #1;
    overlay_clr = 1'b0;
    ovl_ref = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    int acc;
    int exp_ticks;
    int lens[10] = '{3, 3, 3, 3, 7, 15, 15, 0, 9, 1};

    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11", 32'(rd_valid), 0, "rd_valid after reset");
    check("R11", 32'(pclk_ticks), 0, "pclk_ticks after reset");
    check("R8", 32'(overlay_on), 1, "overlay after reset");
    rst_n = 1'b1;

    // R2 R8: overlay maps ROM at low addresses
    bus_op(1, 1, 1, 0, 24'h00_0000, 0, "R8");
    bus_op(1, 1, 1, 0, 24'h00_0A14, 0, "R2");
    // R6 byte lanes
    bus_op(1, 1, 1, 1, 24'h00_0005, 0, "R6");
    bus_op(1, 1, 1, 1, 24'h00_0004, 0, "R6");
    // R4: write under overlay goes to ROM and is dropped
    bus_op(1, 1, 0, 0, 24'h00_0006, 16'hFFFF, "R4");
    bus_op(1, 1, 1, 0, 24'h00_0006, 0, "R4");
    bus_idle(2);

    drop_overlay();
    bus_idle(1);
    check("R8", 32'(overlay_on), 0, "overlay after clear");
    bus_idle(5);
    check("R8", 32'(overlay_on), 0, "overlay stays clear");

    // R5 R7: RAM word and byte writes
    bus_op(1, 1, 0, 0, 24'h00_0100, 16'h1234, "R5");
    bus_op(1, 1, 1, 0, 24'h00_0100, 0, "R5");
    bus_op(1, 1, 0, 1, 24'h00_0100, 16'h77AB, "R7");
    bus_op(1, 1, 1, 0, 24'h00_0100, 0, "R7");
    bus_op(1, 1, 0, 1, 24'h00_0101, 16'h88CD, "R7");
    bus_op(1, 1, 1, 0, 24'h00_0100, 0, "R7");
    bus_op(1, 1, 1, 1, 24'h00_0101, 0, "R6");
    // R3 mirroring
    bus_op(1, 1, 1, 0, 24'h00_1100, 0, "R3");
    bus_op(1, 1, 1, 0, 24'h40_0010, 0, "R2");
    bus_op(1, 1, 1, 0, 24'h40_0810, 0, "R3");
    bus_op(1, 1, 1, 0, 24'h00_0006, 0, "R2");
    // R4: ROM write with overlay off
    bus_op(1, 1, 0, 0, 24'h40_0010, 16'hFFFF, "R4");
    bus_op(1, 1, 1, 0, 24'h40_0010, 0, "R4");
    // R1: peripheral space aliasing RAM word 0x80
    bus_op(1, 1, 0, 0, 24'h80_0100, 16'h5555, "R1");
    bus_op(1, 1, 1, 0, 24'h80_0100, 0, "R1");
    bus_op(1, 1, 1, 0, 24'h00_0100, 0, "R1");
    // R9: no strobe, no operation
    bus_op(1, 0, 0, 0, 24'h00_0100, 16'h0000, "R9");
    bus_op(0, 1, 0, 0, 24'h00_0100, 16'h0000, "R9");
    bus_op(1, 0, 1, 0, 24'h00_0100, 0, "R9");
    bus_op(1, 1, 1, 0, 24'h00_0100, 0, "R9");
    bus_idle(4);
    check("R9", 32'(exp_q.size()), 0, "scoreboard drained");

    // R10 peripheral clock ticks
    acc = 0;
    exp_ticks = 0;
    foreach (lens[i]) begin
      @(posedge clk);
      #1;
      if (i > 0) check("R10", 32'(pclk_ticks), 32'(exp_ticks), "pclk_ticks");
      hc_len = 4'(lens[i]);
      exp_ticks = (acc + lens[i]) / 10;
      acc = (acc + lens[i]) % 10;
    end
    @(posedge clk);
    #1;
    check("R10", 32'(pclk_ticks), 32'(exp_ticks), "pclk_ticks last");
    hc_len = '0;

    // R8: reset restores the overlay
    rst_n = 1'b0;
    #1;
    check("R8", 32'(overlay_on), 1, "overlay after second reset");
    check("R11", 32'(pclk_ticks), 0, "ticks after second reset");
    ovl_ref = 1'b1;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    bus_op(1, 1, 1, 0, 24'h00_0010, 0, "R8");
    bus_idle(3);

    done = 1'b1;
    finish_run();
  end

endmodule